// File: doc/BRIEF.md
# Memory Board Wait and Write-Protect Controller

This block steers accesses to a memory expansion board on an 8-bit parallel system bus. The 64 KB memory space is cut into four 16 KB blocks. A software-written configuration register holds a per-block enable map. An access to an enabled block raises a chip select for the memory array. A strap picks zero or one wait state for the whole board. In one-wait mode, an access to an enabled block pulls the active-low wait request down for a single clock.

Writes to the array are guarded twice. A toggle-switch input passes through a two-flop synchronizer. The write-enable bit in the configuration register resets to 0. The array write strobe fires only when both permit it, so the board comes out of every reset write-protected.

The bus cycle is tracked by a three-state machine:

- **IDLE**: no cycle is being served.
- **ACCESS**: an enabled block is being served.
- **SKIP**: the requested block is disabled, and the cycle is ignored until the request falls.

The transitions are:

- **START_HIT**: IDLE to ACCESS, when a request targets an enabled block.
- **START_MISS**: IDLE to SKIP, when a request targets a disabled block.
- **END_ACCESS**: ACCESS to IDLE, when the request drops.
- **END_SKIP**: SKIP to IDLE, when the request drops.

Top module: `memboard_ctrl`

## Requirements
- R1: After reset, `io_rdata` reads 0x00, `wait_req_n` is 1, and `chip_sel` and `mem_we` are 0.
- R2: A clock edge with `io_cs`=1 and `io_wr`=1 loads the configuration register from `io_wdata`. The register layout is:
  - bits 7:4 are the block-enable map, with bit 4+i enabling block i;
  - bit 3 is the write-enable;
  - bits 2:0 always read 0.
  `io_rdata` always shows the register and changes on no other edge.
- R3: The block index is `bus_blk_addr` (address bits 15:14). In the first cycle of a request (`mem_req` rising from IDLE), `chip_sel` is 1 only if the map bit of that block is set. A request to a disabled block gives no chip select, no wait request and no write strobe at any time.
- R4: With `wait_strap`=1, `wait_req_n` is 0 combinationally in the first cycle of a request to an enabled block, and it is 1 in the cycle after.
- R5: With `wait_strap`=0, `wait_req_n` stays 1.
- R6: `mem_we` is 1 only in ACCESS cycles after the first, while `mem_req` and `bus_wr` are 1. In addition, the synchronized switch must be 1 (enable position; 0 is the inhibit position) and configuration bit 3 must be 1.
- R7: A change of `wp_switch` reaches the write gate after exactly two rising clock edges.
- R8: While a request is held, no further wait request is raised. A new request after `mem_req` falls is decoded afresh.
- R9: Once ACCESS is entered, `chip_sel` holds while `mem_req` stays 1, even if the address or the map changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_blk_addr | input | 2 | Block-select address bits (15:14) |
| mem_req | input | 1 | Memory cycle request, held for the whole cycle |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| io_cs | input | 1 | Configuration port select |
| io_wr | input | 1 | 1 = write to the configuration port |
| io_wdata | input | 8 | Configuration write data |
| io_rdata | output | 8 | Configuration read-back |
| wait_strap | input | 1 | 1 = one wait state, 0 = none |
| wp_switch | input | 1 | Raw toggle switch: 1 = enable, 0 = inhibit |
| wait_req_n | output | 1 | Active-low wait request |
| chip_sel | output | 1 | Memory array chip select |
| mem_we | output | 1 | Gated memory write strobe |

## Verification
A corrupted enable map shows in the first cycle of the next request. The chip select and the wait request appear for the wrong block, or fail to appear. A state machine stuck in ACCESS or SKIP shows in the next request as a missing wait pulse and a chip select that was never re-decoded. Both symptoms appear within one cycle of the rising request.

A synchronizer or register-bit fault shows as a write strobe that appears or vanishes in the second cycle of a write. A wrong synchronizer length shows as the gate opening one edge early or late.

// File: rtl/memboard_pkg.sv
package memboard_pkg;

    // bus-cycle tracking states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_SKIP   = 2'd2
    } cyc_state_t;

endpackage

// File: rtl/memboard_sync.sv
module memboard_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // resets to 0, which is the inhibit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/memboard_cfg.sv
module memboard_cfg #(
    parameter int DATA_W  = 8,
    parameter int NBLK    = 4,
    parameter int WE_BIT  = 3,
    parameter int MAP_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NBLK-1:0]   blk_map,
    output logic              wr_enable
);
    localparam logic [DATA_W-1:0] USED_MASK =
        DATA_W'(((1 << NBLK) - 1) << MAP_LSB) | DATA_W'(1 << WE_BIT);

    logic [DATA_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wdata & USED_MASK;
    end

    assign rdata     = cfg_q;
    assign blk_map   = cfg_q[MAP_LSB +: NBLK];
    assign wr_enable = cfg_q[WE_BIT];

    // R2: register only changes on a port write
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata));
endmodule

// File: rtl/memboard_decode.sv
module memboard_decode #(
    parameter int IDX_W = 2,
    parameter int NBLK  = 4
) (
    input  logic [IDX_W-1:0] blk_addr,
    input  logic [NBLK-1:0]  blk_map,
    output logic             blk_hit
);
    logic [NBLK-1:0] hit_vec;

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        assign hit_vec[i] = (blk_addr == IDX_W'(i)) && blk_map[i];
    end

    assign blk_hit = |hit_vec;

    // R3: at most one block matches
    p_one_block_r3: assert final ($onehot0(hit_vec));
endmodule

// File: rtl/memboard_fsm.sv
module memboard_fsm
    import memboard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_req,
    input  logic blk_hit,
    input  logic one_wait,
    input  logic bus_wr,
    input  logic wr_ok,
    output logic wait_req_n,
    output logic chip_sel,
    output logic mem_we
);
    cyc_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mem_req) state_d = blk_hit ? ST_ACCESS : ST_SKIP; // START_HIT / START_MISS
            end
            ST_ACCESS: if (!mem_req) state_d = ST_IDLE; // END_ACCESS
            ST_SKIP:   if (!mem_req) state_d = ST_IDLE; // END_SKIP
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wait_req_n = 1'b1;
        chip_sel   = 1'b0;
        mem_we     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                chip_sel   = mem_req && blk_hit;
                wait_req_n = !(mem_req && blk_hit && one_wait);
            end
            ST_ACCESS: begin
                chip_sel = mem_req;
                mem_we   = mem_req && bus_wr && wr_ok;
            end
            ST_SKIP: ;
            default: ;
        endcase
    end

    // R4: wait request lasts exactly one clock
    p_wait_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_req_n |=> wait_req_n);
    // R4: a wait request only accompanies a selected block
    p_wait_has_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_req_n |-> chip_sel);
    // R5: zero-wait strap never raises a wait
    p_zero_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !one_wait |-> wait_req_n);
    // R3: a skipped cycle selects nothing
    p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> (!chip_sel && !mem_we));
    // R8: no second wait inside a held cycle
    p_no_rewait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> wait_req_n);
    // R6: the strobe never fires in the decode cycle
    p_we_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !mem_we);
endmodule

// File: rtl/memboard_ctrl.sv
module memboard_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int BLK_W       = 14,
    parameter int DATA_W      = 8,
    parameter int WE_BIT      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = ADDR_W - BLK_W,
    localparam int NBLK       = 1 << IDX_W,
    localparam int MAP_LSB    = DATA_W - NBLK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  bus_blk_addr,
    input  logic              mem_req,
    input  logic              bus_wr,
    input  logic              io_cs,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              wait_strap,
    input  logic              wp_switch,
    output logic              wait_req_n,
    output logic              chip_sel,
    output logic              mem_we
);
    logic [NBLK-1:0] blk_map;
    logic            cfg_we;
    logic            sw_sync;
    logic            blk_hit;
    logic            wr_ok;

    memboard_cfg #(
        .DATA_W(DATA_W), .NBLK(NBLK), .WE_BIT(WE_BIT), .MAP_LSB(MAP_LSB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(io_cs && io_wr), .wdata(io_wdata),
        .rdata(io_rdata), .blk_map(blk_map), .wr_enable(cfg_we)
    );

    memboard_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(wp_switch), .q_sync(sw_sync)
    );

    memboard_decode #(.IDX_W(IDX_W), .NBLK(NBLK)) u_dec (
        .blk_addr(bus_blk_addr), .blk_map(blk_map), .blk_hit(blk_hit)
    );

    assign wr_ok = sw_sync && cfg_we;

    memboard_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .blk_hit(blk_hit),
        .one_wait(wait_strap), .bus_wr(bus_wr), .wr_ok(wr_ok),
        .wait_req_n(wait_req_n), .chip_sel(chip_sel), .mem_we(mem_we)
    );

    // R6: both permissions are needed for a strobe
    p_we_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sw_sync && cfg_we && chip_sel));
endmodule

// File: tb/memboard_ctrl_test.sv
module memboard_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_blk_addr = '0;
    logic       mem_req = 1'b0, bus_wr = 1'b0;
    logic       io_cs = 1'b0, io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       wait_strap = 1'b0, wp_switch = 1'b0;
    logic       wait_req_n, chip_sel, mem_we;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    memboard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_blk_addr(bus_blk_addr), .mem_req(mem_req),
        .bus_wr(bus_wr), .io_cs(io_cs), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .wait_strap(wait_strap), .wp_switch(wp_switch),
        .wait_req_n(wait_req_n), .chip_sel(chip_sel), .mem_we(mem_we)
    );

    // {strap, map[3:0], we_bit, switch, wr, blk[1:0], exp_wait, exp_cs, exp_we}
    localparam int NVEC = 10;
    localparam logic [12:0] VEC [NVEC] = '{
        13'b1_0001_1_1_1_00_1_1_1,
        13'b1_0001_1_1_1_01_0_0_0,
        13'b0_0001_1_1_1_00_0_1_1,
        13'b1_1000_0_1_1_11_1_1_0,
        13'b1_1000_1_0_1_11_1_1_0,
        13'b0_0110_1_1_0_10_0_1_0,
        13'b1_0110_1_1_0_01_1_1_0,
        13'b1_0110_1_1_1_11_0_0_0,
        13'b0_1111_1_1_1_11_0_1_1,
        13'b1_1111_0_0_1_10_1_1_0
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        io_cs = 1'b1; io_wr = 1'b1; io_wdata = v;
        @(negedge clk);
        io_cs = 1'b0; io_wr = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset rdata", io_rdata, 0);
        chk("R1 reset wait_req_n", wait_req_n, 1);
        chk("R1 reset chip_sel", chip_sel, 0);
        chk("R1 reset mem_we", mem_we, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 readback: unused bits read 0
        cfg_write(8'hFF);
        #1 chk("R2 readback", io_rdata, 8'hF8);
        cfg_write(8'h50);
        #1 chk("R2 readback map", io_rdata, 8'h50);

        for (int i = 0; i < NVEC; i++) begin
            logic [12:0] v;
            v = VEC[i];
            cfg_write({v[11:8], v[7], 3'b000});
            wait_strap = v[12];
            wp_switch  = v[6];
            settle(3);
            bus_wr = v[5]; bus_blk_addr = v[4:3]; mem_req = 1'b1;
            #1;
            chk($sformatf("R4/R5 vec%0d first-cycle wait", i), wait_req_n, !v[2]);
            chk($sformatf("R3 vec%0d first-cycle cs", i), chip_sel, v[1]);
            chk($sformatf("R6 vec%0d no strobe in decode cycle", i), mem_we, 0);
            @(negedge clk); #1;
            chk($sformatf("R4 vec%0d wait released", i), wait_req_n, 1);
            chk($sformatf("R3 vec%0d second-cycle cs", i), chip_sel, v[1]);
            chk($sformatf("R6 vec%0d strobe", i), mem_we, v[0]);
            @(negedge clk);
            mem_req = 1'b0;
            #1 chk($sformatf("R3 vec%0d cs drops", i), chip_sel, 0);
            settle(1);
        end

        // R7: switch latency of two edges
        cfg_write(8'h18);
        wait_strap = 1'b0; wp_switch = 1'b0;
        settle(3);
        bus_wr = 1'b1; bus_blk_addr = 2'd0; mem_req = 1'b1;
        @(negedge clk);
        wp_switch = 1'b1;
        @(negedge clk); #1;
        chk("R7 after one edge", mem_we, 0);
        @(negedge clk); #1;
        chk("R7 after two edges", mem_we, 1);

        // R9: address and map change mid-cycle keep the select
        bus_blk_addr = 2'd3;
        cfg_write(8'h08);
        #1 chk("R9 cs held after change", chip_sel, 1);

        // R8: held request never re-raises wait, new request does
        cfg_write(8'h18);
        bus_blk_addr = 2'd0;
        wait_strap = 1'b1;
        settle(2); #1;
        chk("R8 held no wait", wait_req_n, 1);
        @(negedge clk);
        mem_req = 1'b0;
        @(negedge clk);
        mem_req = 1'b1;
        #1 chk("R8 new request waits", wait_req_n, 0);
        @(negedge clk);
        mem_req = 1'b0;

        // R1: reset mid-run clears protection and map
        @(negedge clk);
        rst_n = 1'b0;
        #1 chk("R1 reset clears cfg", io_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        bus_wr = 1'b1; mem_req = 1'b1;
        #1 chk("R3 map cleared no cs", chip_sel, 0);
        @(negedge clk); #1;
        chk("R6 protected after reset", mem_we, 0);
        mem_req = 1'b0;
        settle(2);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule